// File: doc/BRIEF.md
# Register Bank Bus Slave

This block is a slave on an AHB-Lite bus that holds a parameterised array of registers. Each register has one of five access kinds: read-write storage, a read-only value taken straight from a hardware input, event flags that a write clears bit by bit, a value that is cleared by a read, and reserved slots that hold nothing. A peripheral uses it as its software-facing control surface. Its control and status values come in and go out on plain ports, and event pulses set flag bits.

The bank stores the transfer context in the address phase and does the access in the following data phase. It never inserts wait states and always answers OKAY. For every register index it also gives a one-cycle read strobe and a one-cycle write strobe. An attached FIFO can use them to pop or push exactly once per real transfer. Idle or busy cycles never touch any state, even with the select high. With the default map, index 2 is a transmit data slot whose write strobe pushes an outside FIFO, and index 3 is a receive slot whose read strobe pops one.

Top module: `ahb_regbank`

## Requirements
- R1: A transfer is accepted only on a cycle with HSEL high, HREADY high and HTRANS equal to NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) cycles cause no write, no clear and no strobe.
- R2: The register index is HADDR[2 +: clog2(NREG)]. All other address bits are ignored. A read (RW, code 0) returns the value last written by a bus write, and a write stores HWDATA at the end of the data phase.
- R3: A read-only register (code 1) ignores writes. A read returns the matching slice of `ro_value`.
- R4: A write-1-to-clear register (code 2) ORs in `evt_set` bits on every cycle. A write clears exactly the bits where HWDATA is 1, so writing 0x04 clears bit 2 only.
- R5: If an event and a bus clear hit the same flag bit in the same cycle, the bit ends up set.
- R6: A read-to-clear register (code 3) ORs in `evt_set` bits and ignores writes. A qualified read returns its value and then leaves only the bits set by `evt_set` in that data-phase cycle.
- R7: Reserved indices (code 4), and indices at or above NREG, read as zero, ignore writes and raise no strobe.
- R8: `rd_stb[i]` / `wr_stb[i]` is high during the data-phase cycle of a qualified read / write of non-reserved index i, and low otherwise. At most one strobe bit is high at any time.
- R9: HREADYOUT is always 1 and HRESP is always 0 (OKAY).
- R10: After reset, every stored register is zero, and HRDATA and all strobes are zero. HRDATA is zero in any cycle that is not a read data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| HCLK | input | 1 | Bus clock |
| HRESETn | input | 1 | Active-low asynchronous reset |
| HSEL | input | 1 | Slave select |
| HADDR | input | AW | Transfer address |
| HTRANS | input | 2 | Transfer type |
| HWRITE | input | 1 | 1 = write, 0 = read |
| HWDATA | input | DW | Write data (data phase) |
| HREADY | input | 1 | Bus-wide ready; capture only when high |
| HRDATA | output | DW | Read data (data phase) |
| HREADYOUT | output | 1 | Always 1 |
| HRESP | output | 1 | Always 0 |
| ro_value | input | NREG*DW | Read-only values, slice i for index i |
| evt_set | input | NREG*DW | Event bits for W1C / RC registers, slice i for index i |
| rd_stb | output | NREG | One-cycle read strobe per index |
| wr_stb | output | NREG | One-cycle write strobe per index |

## Verification
On every cycle, the assertions check several things: a cycle that is not a real transfer raises no strobe in the next cycle, at most one strobe is high, a read-write register holds its value with no write, event bits are never lost, and a read-to-clear register keeps only the same-cycle events after its read. Only the bench scenarios can show the data-level results. These are the values read back after writes, the bit-exact clearing pattern of a write-1-to-clear, read-only values following their input, reserved slots staying zero, and address bits above the index being ignored. The bench checks all of these against its own model, with mixed random and directed transfers.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [2:0] {
    ACC_RW   = 3'd0,
    ACC_RO   = 3'd1,
    ACC_W1C  = 3'd2,
    ACC_RC   = 3'd3,
    ACC_RSVD = 3'd4
  } acc_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
endpackage

// File: rtl/regbank_capture.sv
module regbank_capture #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic          hready,
  input  logic [IW-1:0] idx_in,
  output logic          sel_q,
  output logic          wr_q,
  output logic [IW-1:0] idx_q
);
  import regbank_pkg::*;

  logic real_xfer;
  assign real_xfer = hsel && hready && (htrans == TR_NONSEQ || htrans == TR_SEQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      idx_q <= '0;
    end else if (hready) begin
      sel_q <= real_xfer;
      wr_q  <= hwrite;
      idx_q <= idx_in;
    end
  end

  // R1: idle/busy type never opens a data phase
  p_idle_no_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !htrans[1]) |=> !sel_q);
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int                   DW   = 32,
  parameter regbank_pkg::acc_e    KIND = regbank_pkg::ACC_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] set_bits,
  input  logic [DW-1:0] ro_in,
  output logic [DW-1:0] rd_val
);
  import regbank_pkg::*;

  logic [DW-1:0] q, q_nxt;

  always_comb begin
    q_nxt = q;
    case (KIND)
      ACC_RW:  if (wr_hit) q_nxt = wdata;
      ACC_W1C: q_nxt = (wr_hit ? (q & ~wdata) : q) | set_bits;
      ACC_RC:  q_nxt = (rd_hit ? '0 : q) | set_bits;
      default: q_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  always_comb begin
    case (KIND)
      ACC_RO:   rd_val = ro_in;
      ACC_RSVD: rd_val = '0;
      default:  rd_val = q;
    endcase
  end

  generate
    if (KIND == ACC_RW) begin : g_chk_rw
      // R2: storage only changes on a write hit
      p_rw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(q));
    end
    if (KIND == ACC_W1C) begin : g_chk_w1c
      // R5: an event bit always lands, even against a clearing write
      p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((q & $past(set_bits)) == $past(set_bits)));
    end
    if (KIND == ACC_RC) begin : g_chk_rc
      // R6: after a qualified read only same-cycle events remain
      p_rc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (q == $past(set_bits)));
    end
  endgenerate
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int IW   = 3
) (
  input  logic [NREG*DW-1:0] vals,
  input  logic [IW-1:0]      idx,
  input  logic               en,
  output logic [DW-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (en) begin
      for (int i = 0; i < NREG; i++) begin
        if (idx == IW'(i)) rdata = vals[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/ahb_regbank.sv
module ahb_regbank #(
  parameter int               NREG = 8,
  parameter int               DW   = 32,
  parameter int               AW   = 12,
  parameter logic [3*NREG-1:0] KIND_MAP = {3'd4, 3'd4, 3'd4, 3'd2, 3'd3, 3'd0, 3'd1, 3'd0}
) (
  input  logic               HCLK,
  input  logic               HRESETn,
  input  logic               HSEL,
  input  logic [AW-1:0]      HADDR,
  input  logic [1:0]         HTRANS,
  input  logic               HWRITE,
  input  logic [DW-1:0]      HWDATA,
  input  logic               HREADY,
  output logic [DW-1:0]      HRDATA,
  output logic               HREADYOUT,
  output logic               HRESP,
  input  logic [NREG*DW-1:0] ro_value,
  input  logic [NREG*DW-1:0] evt_set,
  output logic [NREG-1:0]    rd_stb,
  output logic [NREG-1:0]    wr_stb
);
  import regbank_pkg::*;

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          sel_q, wr_q;
  logic [IW-1:0] idx_q;
  logic [NREG*DW-1:0] vals;

  logic addr_unused;
  assign addr_unused = ^{HADDR[AW-1:2+IW], HADDR[1:0]};

  regbank_capture #(.IW(IW)) u_cap (
    .clk    (HCLK),
    .rst_n  (HRESETn),
    .hsel   (HSEL),
    .htrans (HTRANS),
    .hwrite (HWRITE),
    .hready (HREADY),
    .idx_in (HADDR[2 +: IW]),
    .sel_q  (sel_q),
    .wr_q   (wr_q),
    .idx_q  (idx_q)
  );

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam acc_e KIND = acc_e'(KIND_MAP[3*i +: 3]);
      logic hit;
      assign hit = sel_q && (idx_q == IW'(i));

      regbank_cell #(.DW(DW), .KIND(KIND)) u_cell (
        .clk      (HCLK),
        .rst_n    (HRESETn),
        .wr_hit   (hit && wr_q),
        .rd_hit   (hit && !wr_q),
        .wdata    (HWDATA),
        .set_bits (evt_set[i*DW +: DW]),
        .ro_in    (ro_value[i*DW +: DW]),
        .rd_val   (vals[i*DW +: DW])
      );

      if (KIND == ACC_RSVD) begin : g_nostb
        assign rd_stb[i] = 1'b0;
        assign wr_stb[i] = 1'b0;
      end else begin : g_stb
        assign rd_stb[i] = hit && !wr_q;
        assign wr_stb[i] = hit && wr_q;
      end
    end
  endgenerate

  regbank_rdmux #(.DW(DW), .NREG(NREG), .IW(IW)) u_mux (
    .vals  (vals),
    .idx   (idx_q),
    .en    (sel_q && !wr_q),
    .rdata (HRDATA)
  );

  assign HREADYOUT = 1'b1;
  assign HRESP     = 1'b0;

  // R8: a single access lights at most one strobe
  p_one_rd_r8: assert property (@(posedge HCLK) disable iff (!HRESETn) $onehot0(rd_stb));
  p_one_wr_r8: assert property (@(posedge HCLK) disable iff (!HRESETn) $onehot0(wr_stb));
  p_rw_excl_r8: assert property (@(posedge HCLK) disable iff (!HRESETn)
    !((rd_stb != '0) && (wr_stb != '0)));
  // R1: a non-transfer cycle yields no side effect in the next cycle
  p_no_stb_idle_r1: assert property (@(posedge HCLK) disable iff (!HRESETn)
    !(HSEL && HREADY && HTRANS[1]) |=> (rd_stb == '0 && wr_stb == '0));
endmodule

// File: tb/ahb_regbank_test.sv
module ahb_regbank_test;
  localparam int NREG = 8;
  localparam int DW   = 32;
  localparam int AW   = 12;

  logic HCLK = 1'b0;
  logic HRESETn = 1'b0;
  logic HSEL = 1'b0;
  logic [AW-1:0] HADDR = '0;
  logic [1:0] HTRANS = 2'b00;
  logic HWRITE = 1'b0;
  logic [DW-1:0] HWDATA = '0;
  logic HREADY = 1'b1;
  logic [DW-1:0] HRDATA;
  logic HREADYOUT, HRESP;
  logic [NREG*DW-1:0] ro_value = '0;
  logic [NREG*DW-1:0] evt_set = '0;
  logic [NREG-1:0] rd_stb, wr_stb;

  int compared = 0;
  int mismatched = 0;
  logic [DW-1:0] model [NREG];

  always #10 HCLK = ~HCLK;

  ahb_regbank #(.NREG(NREG), .DW(DW), .AW(AW)) uut (.*);

  function automatic int kind_of(int i);
    case (i)
      0: return 0; 1: return 1; 2: return 0; 3: return 3; 4: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_read(int i);
    case (kind_of(i))
      1: return ro_value[i*DW +: DW];
      4: return '0;
      default: return model[i];
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transfer: address phase, then data phase with optional event bits
  task automatic xfer(bit hs, bit [1:0] tr, bit rdy, bit wr, int idx,
                      logic [DW-1:0] wd, logic [DW-1:0] setv, string req);
    bit acc;
    logic [DW-1:0] er;
    logic [NREG-1:0] erd, ewr;
    acc = hs && rdy && tr[1];
    @(negedge HCLK);
    HSEL = hs; HTRANS = tr; HREADY = rdy; HWRITE = wr;
    HADDR = {$urandom_range(0, 127), idx[2:0], 2'b00};
    evt_set = '0;
    @(negedge HCLK);
    HSEL = 1'b0; HTRANS = 2'b00; HREADY = 1'b1; HWDATA = wd;
    evt_set[idx*DW +: DW] = setv;
    #1;
    er  = (acc && !wr) ? exp_read(idx) : '0;
    erd = (acc && !wr && kind_of(idx) != 4) ? NREG'(1) << idx : '0;
    ewr = (acc &&  wr && kind_of(idx) != 4) ? NREG'(1) << idx : '0;
    chk({req, " R10/R2 rdata"}, HRDATA, er);
    chk({req, " R8 rd_stb"}, DW'(rd_stb), DW'(erd));
    chk({req, " R8 wr_stb"}, DW'(wr_stb), DW'(ewr));
    @(posedge HCLK);
    #1;
    case (kind_of(idx))
      0: if (acc && wr) model[idx] = wd;
      2: model[idx] = ((acc && wr) ? (model[idx] & ~wd) : model[idx]) | setv;
      3: model[idx] = ((acc && !wr) ? '0 : model[idx]) | setv;
      default: ;
    endcase
    evt_set = '0;
  endtask

  initial begin
    #(20 * 200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NREG; i++) begin
      model[i] = '0;
      ro_value[i*DW +: DW] = $urandom;
    end
    #1;
    // R10: reset state
    chk("R10 reset rdata", HRDATA, '0);
    chk("R10 reset strobes", DW'({rd_stb, wr_stb}), '0);
    chk("R9 readyout/resp", DW'({HREADYOUT, HRESP}), DW'(2'b10));
    repeat (3) @(negedge HCLK);
    HRESETn = 1'b1;

    xfer(1, 2'b10, 1, 0, 0, '0, '0, "R10 rw after reset");
    xfer(1, 2'b10, 1, 1, 0, 32'hCAFE_0123, '0, "R2 write");
    xfer(1, 2'b11, 1, 0, 0, '0, '0, "R2 readback");
    xfer(1, 2'b10, 1, 1, 1, 32'hFFFF_FFFF, '0, "R3 ro write");
    xfer(1, 2'b10, 1, 0, 1, '0, '0, "R3 ro read");
    // R4: set flags then write 0x04
    xfer(1, 2'b00, 1, 0, 4, '0, 32'h0000_00FF, "R4 evt set");
    xfer(1, 2'b10, 1, 1, 4, 32'h0000_0004, '0, "R4 clear bit2");
    xfer(1, 2'b10, 1, 0, 4, '0, '0, "R4 read 0xFB");
    chk("R4 value", model[4], 32'h0000_00FB);
    // R5: set and clear same bit same cycle
    xfer(1, 2'b10, 1, 1, 4, 32'h0000_0001, 32'h0000_0001, "R5 set vs clear");
    xfer(1, 2'b10, 1, 0, 4, '0, '0, "R5 bit survives");
    // R6: idle and busy with select do not clear
    xfer(1, 2'b00, 1, 0, 3, '0, 32'h0000_00A5, "R6 evt");
    xfer(1, 2'b00, 1, 0, 3, '0, '0, "R6 idle no clear");
    xfer(1, 2'b01, 1, 0, 3, '0, '0, "R6 busy no clear");
    xfer(1, 2'b10, 0, 0, 3, '0, '0, "R1 hready low");
    xfer(1, 2'b10, 1, 0, 3, '0, 32'h0000_0100, "R6 read with evt");
    xfer(1, 2'b10, 1, 0, 3, '0, '0, "R6 only evt left");
    xfer(1, 2'b10, 1, 1, 3, 32'hFFFF_FFFF, '0, "R6 write ignored");
    xfer(1, 2'b10, 1, 0, 3, '0, '0, "R6 after write");
    // R7: reserved
    xfer(1, 2'b10, 1, 1, 6, 32'h1234_5678, '0, "R7 rsvd write");
    xfer(1, 2'b10, 1, 0, 6, '0, '0, "R7 rsvd read");
    xfer(0, 2'b10, 1, 1, 0, 32'hDEAD_BEEF, '0, "R1 no hsel");
    xfer(1, 2'b10, 1, 0, 0, '0, '0, "R1 unchanged");

    for (int n = 0; n < 600; n++) begin
      int idx;
      bit hs, rdy, wr;
      bit [1:0] tr;
      logic [DW-1:0] setv;
      idx = $urandom_range(0, NREG - 1);
      hs  = ($urandom_range(0, 9) != 0);
      rdy = ($urandom_range(0, 9) != 0);
      tr  = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
      wr  = $urandom_range(0, 1);
      setv = ($urandom_range(0, 3) == 0) ? $urandom : '0;
      if (n == 300) ro_value[DW +: DW] = $urandom;
      xfer(hs, tr, rdy, wr, idx, $urandom, setv, "R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule